// File: doc/BRIEF.md
# TLB Write Index Consistency Checker

This block sits in front of the write port of a two-way set-associative translation buffer whose storage holds 2048 entries. Each store to the buffer's data registers presents four things: the virtual address held in the tag-access register, the page size (8 KB or 4 MB), a two-bit replacement mode, and the index field carried by the incoming entry. From the page size and mode, the block picks the address bits that form the set index. It compares those bits with the index field, and then either issues the write or suppresses it. When it issues a write, it also supplies the linear entry number inside the 2048-entry array.

An entry written with its valid bit clear skips the comparison. Software uses this to invalidate chosen entries without first setting up a matching tag address. A 4 MB write under a mode that defines no 4 MB region is refused, and a one-cycle configuration error flag is raised. All decisions are registered, so results appear on the clock edge after the store strobe.

Top module: `tlb_wr_idx_guard`

## Requirements
- R1: For an 8 KB page (`pg_big_i`=0), address bits [21:13] are compared with all 9 bits of `ent_idx_i`. When `ent_valid_i`=1 and they differ, `wr_en_o` stays 0 in the cycle after the strobe.
- R2: For a 4 MB page (`pg_big_i`=1) with `rmode_i`=2'b10, address bits [30:22] are compared with all 9 bits of `ent_idx_i`. A mismatch on a valid entry suppresses the write.
- R3: For a 4 MB page with `rmode_i`=2'b11, only address bits [29:22] are compared, against `ent_idx_i[7:0]`. Address bit 30 and `ent_idx_i[8]` are ignored.
- R4: When `ent_valid_i`=0 and the page/mode pair has a region, the write is always issued, whatever the address bits hold.
- R5: For an 8 KB page, under any mode, the entry number is `way_i`*512 + `ent_idx_i`. This lies in 0..1023.
- R6: For a 4 MB page with mode 2'b10, the entry number is 1024 + `way_i`*512 + `ent_idx_i`.
- R7: For a 4 MB page with mode 2'b11, the entry number is 1024 + `way_i`*256 + `ent_idx_i[7:0]`. It is never 1536 or above.
- R8: A 4 MB store under mode 2'b00 or 2'b01 issues no write and sets `cfg_err_o` for exactly the one cycle after the strobe. This holds whatever the valid bit is.
- R9: `wr_en_o`, `entry_num_o` and `cfg_err_o` reflect a strobe in the following cycle only. Otherwise `wr_en_o`=0, `cfg_err_o`=0 and `entry_num_o`=0, and `entry_num_o` is also 0 whenever `wr_en_o`=0.
- R10: An active-low `rst_n` clears all three outputs at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_i | input | 1 | One-cycle strobe for a store to the data registers |
| tag_va_i | input | VA_W (64) | Virtual address from the tag-access register |
| pg_big_i | input | 1 | Page size: 0 = 8 KB, 1 = 4 MB |
| rmode_i | input | 2 | Replacement mode |
| ent_valid_i | input | 1 | Valid bit of the entry being written |
| ent_idx_i | input | SET_W (9) | Index field of the entry being written |
| way_i | input | 1 | Target way |
| wr_en_o | output | 1 | Registered write enable to the array |
| entry_num_o | output | SET_W+2 (11) | Linear entry number of the write |
| cfg_err_o | output | 1 | One-cycle flag for a 4 MB store with no 4 MB region |

## Verification
The bound checker enforces several rules on every cycle:
- a write or error only ever follows a strobe;
- an error never comes with a write, and it is caused only by a 4 MB store under the low modes;
- invalid entries in a legal configuration always pass;
- 8 KB writes stay below 1024, and narrow-mode 4 MB writes stay below 1536;
- the entry number is zero whenever no write is issued.

Only the bench's scenarios can show the exact bit slices and numbers. These include which address bits count for each page/mode pair, that bit 30 and index bit 8 are ignored in the narrow mode, the precise entry arithmetic for each way, and the asynchronous clear taking effect between clock edges.

// File: rtl/tlb_wig_pkg.sv
package tlb_wig_pkg;

   typedef enum logic [1:0] {
      RMODE_LOW0  = 2'b00,
      RMODE_LOW1  = 2'b01,
      RMODE_WIDE  = 2'b10,
      RMODE_NARROW = 2'b11
   } rmode_e;

   typedef enum logic {
      PAGE_8K = 1'b0,
      PAGE_4M = 1'b1
   } page_e;

   // A 4 MB region exists only when the upper mode bit is set.
   function automatic logic big_region_ok(input rmode_e m);
      return (m == RMODE_WIDE) || (m == RMODE_NARROW);
   endfunction

endpackage

// File: rtl/tlb_wig_slice.sv
module tlb_wig_slice
   import tlb_wig_pkg::*;
#(
   parameter int VA_W      = 64,
   parameter int SET_W     = 9,
   parameter int SMALL_LSB = 13,
   parameter int BIG_LSB   = 22
) (
   input  logic [VA_W-1:0]  va_i,
   input  page_e            page_i,
   input  rmode_e           mode_i,
   output logic [SET_W-1:0] va_idx_o,
   output logic [SET_W-1:0] idx_mask_o,
   output logic             narrow_o,
   output logic             region_ok_o
);

   localparam logic [SET_W-1:0] FULL_MASK   = '1;
   localparam logic [SET_W-1:0] NARROW_MASK = FULL_MASK >> 1;

   if (VA_W < BIG_LSB + SET_W) begin : g_bad_va
      $error("tlb_wig_slice: VA_W too narrow for the 4 MB index slice");
   end
   if (BIG_LSB <= SMALL_LSB) begin : g_bad_lsb
      $error("tlb_wig_slice: BIG_LSB must lie above SMALL_LSB");
   end

   always_comb begin
      narrow_o    = (page_i == PAGE_4M) && (mode_i == RMODE_NARROW);
      region_ok_o = (page_i == PAGE_8K) || big_region_ok(mode_i);
      va_idx_o    = (page_i == PAGE_4M) ? va_i[BIG_LSB +: SET_W]
                                        : va_i[SMALL_LSB +: SET_W];
      idx_mask_o  = narrow_o ? NARROW_MASK : FULL_MASK;
   end

endmodule

// File: rtl/tlb_wig_cmp.sv
module tlb_wig_cmp #(
   parameter int SET_W = 9
) (
   input  logic [SET_W-1:0] va_idx_i,
   input  logic [SET_W-1:0] ent_idx_i,
   input  logic [SET_W-1:0] mask_i,
   output logic             match_o
);

   logic [SET_W-1:0] bit_ok;

   for (genvar b = 0; b < SET_W; b++) begin : g_bit
      assign bit_ok[b] = !mask_i[b] || (va_idx_i[b] == ent_idx_i[b]);
   end

   assign match_o = &bit_ok;

endmodule

// File: rtl/tlb_wig_map.sv
module tlb_wig_map
   import tlb_wig_pkg::*;
#(
   parameter int SET_W     = 9,
   parameter bit MAP_ADDER = 1'b0,
   localparam int ENT_W    = SET_W + 2
) (
   input  page_e            page_i,
   input  logic             narrow_i,
   input  logic             way_i,
   input  logic [SET_W-1:0] idx_i,
   input  logic [SET_W-1:0] mask_i,
   output logic [ENT_W-1:0] num_o
);

   localparam int REGION = 2 ** SET_W;
   localparam int HALF   = REGION / 2;

   logic [SET_W-1:0] idx_m;
   assign idx_m = idx_i & mask_i;

   if (SET_W < 2) begin : g_bad_set
      $error("tlb_wig_map: SET_W must be at least 2");
   end

   if (MAP_ADDER) begin : g_adder
      logic [ENT_W-1:0] base, way_off;
      always_comb begin
         base    = (page_i == PAGE_4M) ? ENT_W'(2 * REGION) : '0;
         way_off = !way_i   ? '0
                 : narrow_i ? ENT_W'(HALF)
                 :            ENT_W'(REGION);
         num_o   = base + way_off + ENT_W'(idx_m);
      end
   end else begin : g_concat
      // Region bases and way offsets are powers of two, so the sum is a
      // field concatenation.
      always_comb begin
         if (narrow_i)
            num_o = {1'b1, 1'b0, way_i, idx_m[SET_W-2:0]};
         else
            num_o = {page_i == PAGE_4M, way_i, idx_m};
      end
   end

endmodule

// File: rtl/tlb_wr_idx_guard.sv
module tlb_wr_idx_guard
   import tlb_wig_pkg::*;
#(
   parameter int VA_W      = 64,
   parameter int SET_W     = 9,
   parameter int SMALL_LSB = 13,
   parameter int BIG_LSB   = 22,
   parameter bit MAP_ADDER = 1'b0,
   localparam int ENT_W    = SET_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             store_i,
   input  logic [VA_W-1:0]  tag_va_i,
   input  logic             pg_big_i,
   input  logic [1:0]       rmode_i,
   input  logic             ent_valid_i,
   input  logic [SET_W-1:0] ent_idx_i,
   input  logic             way_i,
   output logic             wr_en_o,
   output logic [ENT_W-1:0] entry_num_o,
   output logic             cfg_err_o
);

   page_e            page;
   rmode_e           mode;
   logic [SET_W-1:0] va_idx, idx_mask;
   logic             narrow, region_ok, match, do_write;
   logic [ENT_W-1:0] num_c;

   assign page = page_e'(pg_big_i);
   assign mode = rmode_e'(rmode_i);

   tlb_wig_slice #(
      .VA_W(VA_W), .SET_W(SET_W), .SMALL_LSB(SMALL_LSB), .BIG_LSB(BIG_LSB)
   ) slice_i (
      .va_i(tag_va_i), .page_i(page), .mode_i(mode),
      .va_idx_o(va_idx), .idx_mask_o(idx_mask),
      .narrow_o(narrow), .region_ok_o(region_ok)
   );

   tlb_wig_cmp #(.SET_W(SET_W)) cmp_i (
      .va_idx_i(va_idx), .ent_idx_i(ent_idx_i), .mask_i(idx_mask),
      .match_o(match)
   );

   tlb_wig_map #(.SET_W(SET_W), .MAP_ADDER(MAP_ADDER)) map_i (
      .page_i(page), .narrow_i(narrow), .way_i(way_i),
      .idx_i(ent_idx_i), .mask_i(idx_mask), .num_o(num_c)
   );

   // An invalid entry bypasses the index comparison (demap path).
   assign do_write = region_ok && (!ent_valid_i || match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o     <= 1'b0;
         entry_num_o <= '0;
         cfg_err_o   <= 1'b0;
      end else begin
         wr_en_o     <= store_i && do_write;
         entry_num_o <= (store_i && do_write) ? num_c : '0;
         cfg_err_o   <= store_i && !region_ok;
      end
   end

endmodule

// File: rtl/tlb_wig_chk.sv
module tlb_wig_chk #(
   parameter int SET_W   = 9,
   localparam int ENT_W  = SET_W + 2,
   localparam int REGION = 2 ** SET_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             store_i,
   input logic             pg_big_i,
   input logic [1:0]       rmode_i,
   input logic             ent_valid_i,
   input logic             wr_en_o,
   input logic [ENT_W-1:0] entry_num_o,
   input logic             cfg_err_o
);

   // R9
   we_follows_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(store_i));

   // R9
   idle_num_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_o |-> entry_num_o == '0);

   // R8
   err_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> !wr_en_o);

   // R8
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> $past(store_i && pg_big_i && !rmode_i[1]));

   // R4
   demap_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (store_i && !ent_valid_i && (!pg_big_i || rmode_i[1])) |=> wr_en_o);

   // R5
   small_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !$past(pg_big_i)) |-> entry_num_o < ENT_W'(2 * REGION));

   // R7
   narrow_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(pg_big_i) && $past(rmode_i) == 2'b11)
         |-> entry_num_o < ENT_W'(3 * REGION));

endmodule

bind tlb_wr_idx_guard tlb_wig_chk #(.SET_W(SET_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .store_i(store_i), .pg_big_i(pg_big_i),
   .rmode_i(rmode_i), .ent_valid_i(ent_valid_i), .wr_en_o(wr_en_o),
   .entry_num_o(entry_num_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tlb_wr_idx_guard_tb_top.sv
module tlb_wr_idx_guard_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        big;
      logic [1:0]  mode;
      logic        valid;
      logic        way;
      logic [63:0] va;
      logic [8:0]  idx;
      logic        we;
      logic [10:0] num;
      logic        err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      // R1/R5: 8 KB match, noise in bits 22 and 12
      '{1'b0, 2'b00, 1'b1, 1'b0, 64'h0000_0000_0074_B000, 9'h1A5, 1'b1, 11'd421,  1'b0, 4'd5},
      // R5: 8 KB way 1 under narrow mode, bit 30 noise
      '{1'b0, 2'b11, 1'b1, 1'b1, 64'h0000_0000_401F_E000, 9'h0FF, 1'b1, 11'd767,  1'b0, 4'd5},
      // R1: 8 KB mismatch
      '{1'b0, 2'b00, 1'b1, 1'b0, 64'h0000_0000_0002_0000, 9'h011, 1'b0, 11'd0,    1'b0, 4'd1},
      // R2/R6: wide mode way 0
      '{1'b1, 2'b10, 1'b1, 1'b0, 64'h0000_0000_70E0_0000, 9'h1C3, 1'b1, 11'd1475, 1'b0, 4'd6},
      // R6: wide mode way 1 top entry
      '{1'b1, 2'b10, 1'b1, 1'b1, 64'h0000_0000_7FC0_0000, 9'h1FF, 1'b1, 11'd2047, 1'b0, 4'd6},
      // R2: wide mode mismatch in bit 30
      '{1'b1, 2'b10, 1'b1, 1'b0, 64'h0000_0000_7FC0_0000, 9'h0FF, 1'b0, 11'd0,    1'b0, 4'd2},
      // R3/R7: narrow mode, bit 30 ignored
      '{1'b1, 2'b11, 1'b1, 1'b0, 64'h0000_0000_4F00_0000, 9'h03C, 1'b1, 11'd1084, 1'b0, 4'd3},
      // R3/R7: narrow way 1, index bit 8 ignored
      '{1'b1, 2'b11, 1'b1, 1'b1, 64'h0000_0000_3FC0_0000, 9'h1FF, 1'b1, 11'd1535, 1'b0, 4'd7},
      // R3: narrow mismatch
      '{1'b1, 2'b11, 1'b1, 1'b0, 64'h0000_0000_3FC0_0000, 9'h0FE, 1'b0, 11'd0,    1'b0, 4'd3},
      // R4: 8 KB invalid entry, mismatch bypassed
      '{1'b0, 2'b01, 1'b0, 1'b1, 64'h0000_0000_0002_0000, 9'h0AB, 1'b1, 11'd683,  1'b0, 4'd4},
      // R4: narrow invalid entry, mismatch bypassed
      '{1'b1, 2'b11, 1'b0, 1'b1, 64'h0000_0000_0000_0000, 9'h1AB, 1'b1, 11'd1451, 1'b0, 4'd4},
      // R8: 4 MB under mode 00
      '{1'b1, 2'b00, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 9'h000, 1'b0, 11'd0,    1'b1, 4'd8},
      // R8: 4 MB under mode 01, invalid entry still refused
      '{1'b1, 2'b01, 1'b0, 1'b1, 64'h0000_0000_7FC0_0000, 9'h1FF, 1'b0, 11'd0,    1'b1, 4'd8},
      // R5: 8 KB entry 0
      '{1'b0, 2'b01, 1'b1, 1'b0, 64'hFFFF_FFFF_FFC0_1FFF, 9'h000, 1'b1, 11'd0,    1'b0, 4'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        store_i = 1'b0;
   logic [63:0] tag_va_i = '0;
   logic        pg_big_i = 1'b0;
   logic [1:0]  rmode_i = 2'b00;
   logic        ent_valid_i = 1'b0;
   logic [8:0]  ent_idx_i = '0;
   logic        way_i = 1'b0;
   logic        wr_en_o, cfg_err_o;
   logic [10:0] entry_num_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tlb_wr_idx_guard dut_i (
      .clk(clk), .rst_n(rst_n), .store_i(store_i), .tag_va_i(tag_va_i),
      .pg_big_i(pg_big_i), .rmode_i(rmode_i), .ent_valid_i(ent_valid_i),
      .ent_idx_i(ent_idx_i), .way_i(way_i), .wr_en_o(wr_en_o),
      .entry_num_o(entry_num_o), .cfg_err_o(cfg_err_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_outs(input string tag, input int we, input int num, input int err);
      check({tag, " wr_en"}, int'(wr_en_o), we);
      check({tag, " entry_num"}, int'(entry_num_o), num);
      check({tag, " cfg_err"}, int'(cfg_err_o), err);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: outputs cleared during reset
      #(CLK_PERIOD * 2 + 2);
      check_outs("R10 reset", 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: no strobe, outputs idle
      @(negedge clk);
      @(negedge clk);
      check_outs("R9 idle", 0, 0, 0);

      foreach (VECS[i]) begin
         @(negedge clk);
         pg_big_i    = VECS[i].big;
         rmode_i     = VECS[i].mode;
         ent_valid_i = VECS[i].valid;
         way_i       = VECS[i].way;
         tag_va_i    = VECS[i].va;
         ent_idx_i   = VECS[i].idx;
         store_i     = 1'b1;
         @(negedge clk);
         store_i = 1'b0;
         check_outs($sformatf("R%0d vec%0d", VECS[i].req, i),
                    int'(VECS[i].we), int'(VECS[i].num), int'(VECS[i].err));
         @(negedge clk);
         // R9: results last only one cycle
         check_outs($sformatf("R9 vec%0d after", i), 0, 0, 0);
      end

      // R9: inputs that would write but no strobe
      pg_big_i = 1'b0; rmode_i = 2'b00; ent_valid_i = 1'b0; way_i = 1'b1;
      ent_idx_i = 9'h055;
      @(negedge clk);
      @(negedge clk);
      check_outs("R9 no strobe", 0, 0, 0);

      // R10: asynchronous clear between edges
      store_i = 1'b1;
      @(negedge clk);
      store_i = 1'b0;
      check_outs("R10 pre", 1, 512 + 85, 0);
      #1 rst_n = 1'b0;
      #1 check_outs("R10 async", 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule